// File: doc/BRIEF.md
# Modulo 2^n+1 Inverted End-Around-Carry Final Adder

This block is the last stage of a modulo 2^n+1 datapath, for example a residue subtractor or multiplier that has already reduced its operands to two n-bit carry-save vectors. It takes those two vectors and adds them combinationally with a constant increment. It returns the weighted residue (C + S + 1) mod (2^n+1) on n+1 output bits.

The n low result bits come from a parallel-prefix carry tree. The tree uses the minimum-depth recursive-doubling arrangement. The carry into the low end is the inverse of the tree's carry-out, and it is injected after the tree by a carry-increment row. This keeps the end-around carry off the tree's critical path.

The result's top bit is read straight off the tree's group signals over all n positions, so no separate comparator is needed. A parameter chooses between two forms of the bitwise propagate term, exclusive-OR or inclusive-OR. The top-bit detection adapts to each form.

Top module: `mod2n1_eac_adder`

## Requirements
- R1: For every pair of inputs, r_o equals (c_i + s_i + 1) mod (2^N + 1), and r_o never exceeds 2^N.
- R2: When c_i + s_i is at least 2^N, r_o[N] is 0 and r_o[N-1:0] equals c_i + s_i - 2^N. The internal carry-out of c_i + s_i is 1 in this case, and the end-around carry-in is 0.
- R3: When c_i + s_i is below 2^N - 1, r_o[N] is 0 and r_o equals c_i + s_i + 1.
- R4: r_o[N] is 1 if and only if c_i and s_i are bitwise complementary, meaning c_i XOR s_i is all ones.
- R5: Whenever r_o[N] is 1, r_o[N-1:0] is all zeros, so r_o equals exactly 2^N.
- R6: With the propagate form set to inclusive-OR (PROP = PROP_OR), r_o is identical to the exclusive-OR form (PROP = PROP_XOR) for every input pair. In the inclusive-OR form, the top bit requires group propagate true and group generate false.
- R7: The block is correct for any N from 2 to 32, including both extremes of that range.
- R8: The corner values hold: c_i = s_i = 0 gives r_o = 1, and c_i = s_i = all ones gives r_o = 2^N - 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| c_i | input | N | Carry vector operand |
| s_i | input | N | Sum vector operand |
| r_o | output | N+1 | Weighted residue (c_i + s_i + 1) mod (2^N+1) |

## Verification
Every operand pair is applied for widths 2, 4 and 6. This sweep covers each of the three sum regions exhaustively: below 2^N-1, exactly 2^N-1, and 2^N or above. It therefore separates a wrong end-around carry polarity (which breaks R2 and R3) from a wrong top-bit detector (which breaks R4 and R5). Widths 16 and 32 receive seeded random pairs, mixed with explicitly built complementary pairs and the all-zero and all-one corners. This exercises the deepest prefix levels, where a misrouted tree node only shows for long carry chains. Each width is instantiated in both propagate forms, and the two outputs are compared against each other as well as against the reference, which exposes a top-bit rule that ignores the group generate term in the inclusive-OR form.

// File: rtl/eac_pkg.sv
package eac_pkg;

  typedef enum logic {
    PROP_XOR = 1'b0,
    PROP_OR  = 1'b1
  } prop_e;

  typedef struct packed {
    logic g;
    logic p;
  } gp_t;

  // prefix operator: hi covers more significant span, lo the adjacent lower span
  function automatic gp_t gp_dot(gp_t hi, gp_t lo);
    gp_t res;
    res.g = hi.g | (hi.p & lo.g);
    res.p = hi.p & lo.p;
    return res;
  endfunction

endpackage

// File: rtl/eac_pregen.sv
module eac_pregen #(
  parameter int            N    = 8,
  parameter eac_pkg::prop_e PROP = eac_pkg::PROP_XOR
) (
  input  logic [N-1:0]         c_i,
  input  logic [N-1:0]         s_i,
  output eac_pkg::gp_t [N-1:0] gp_o,
  output logic [N-1:0]         h_o
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign gp_o[i].g = c_i[i] & s_i[i];
    if (PROP == eac_pkg::PROP_OR) begin : g_or
      assign gp_o[i].p = c_i[i] | s_i[i];
    end else begin : g_xor
      assign gp_o[i].p = c_i[i] ^ s_i[i];
    end
    assign h_o[i] = c_i[i] ^ s_i[i];
  end

endmodule

// File: rtl/eac_lf_tree.sv
module eac_lf_tree #(
  parameter int            N    = 8,
  parameter eac_pkg::prop_e PROP = eac_pkg::PROP_XOR
) (
  input  eac_pkg::gp_t [N-1:0] gp_i,
  output logic [N-1:0]         grp_g_o,
  output logic [N-1:0]         grp_p_o
);

  localparam int LVL = (N > 1) ? $clog2(N) : 1;

  for (genvar l = 0; l < LVL; l++) begin : g_lvl
    eac_pkg::gp_t [N-1:0] src;
    eac_pkg::gp_t [N-1:0] nd;

    if (l == 0) begin : g_first
      assign src = gp_i;
    end else begin : g_next
      assign src = g_lvl[l-1].nd;
    end

    for (genvar i = 0; i < N; i++) begin : g_node
      if (((i >> l) & 1) == 1) begin : g_dot
        localparam int J = ((i >> l) << l) - 1;
        assign nd[i] = eac_pkg::gp_dot(src[i], src[J]);
      end else begin : g_pass
        assign nd[i] = src[i];
      end
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_out
    assign grp_g_o[i] = g_lvl[LVL-1].nd[i].g;
    assign grp_p_o[i] = g_lvl[LVL-1].nd[i].p;
  end

  // leaf propagate product against the tree's top span
  logic [N-1:0] leaf_p;
  for (genvar i = 0; i < N; i++) begin : g_leaf
    assign leaf_p[i] = gp_i[i].p;
  end

  always_comb begin
    if (PROP == eac_pkg::PROP_XOR) begin
      AST_TOP_SPAN_PROP: assert (grp_p_o[N-1] == (&leaf_p))  // R4
        else $error("group propagate mismatch");
    end
  end

endmodule

// File: rtl/eac_cinc.sv
module eac_cinc #(
  parameter int N = 8
) (
  input  logic [N-1:0] h_i,
  input  logic [N-1:0] grp_g_i,
  input  logic [N-1:0] grp_p_i,
  output logic [N-1:0] sum_o
);

  logic         cin;
  logic [N-1:0] car;

  // inverted end-around carry
  assign cin    = ~grp_g_i[N-1];
  assign car[0] = cin;

  for (genvar i = 1; i < N; i++) begin : g_inc
    assign car[i] = grp_g_i[i-1] | (grp_p_i[i-1] & cin);
  end

  assign sum_o = h_i ^ car;

  always_comb begin
    if (grp_p_i[N-1] && !grp_g_i[N-1]) begin
      AST_COMPLEMENT_LOW_ZERO: assert (sum_o == '0)  // R5
        else $error("low bits not cleared on complementary inputs");
    end
  end

endmodule

// File: rtl/mod2n1_eac_adder.sv
module mod2n1_eac_adder #(
  parameter int             N    = 8,
  parameter eac_pkg::prop_e PROP = eac_pkg::PROP_XOR
) (
  input  logic [N-1:0] c_i,
  input  logic [N-1:0] s_i,
  output logic [N:0]   r_o
);

  eac_pkg::gp_t [N-1:0] leaf_gp;
  logic [N-1:0]         half_sum;
  logic [N-1:0]         grp_g;
  logic [N-1:0]         grp_p;
  logic [N-1:0]         low_sum;
  logic                 msb;

  eac_pregen #(.N(N), .PROP(PROP)) i_pregen (
    .c_i  (c_i),
    .s_i  (s_i),
    .gp_o (leaf_gp),
    .h_o  (half_sum)
  );

  eac_lf_tree #(.N(N), .PROP(PROP)) i_tree (
    .gp_i    (leaf_gp),
    .grp_g_o (grp_g),
    .grp_p_o (grp_p)
  );

  eac_cinc #(.N(N)) i_cinc (
    .h_i     (half_sum),
    .grp_g_i (grp_g),
    .grp_p_i (grp_p),
    .sum_o   (low_sum)
  );

  // top bit from the full-span group signals
  if (PROP == eac_pkg::PROP_OR) begin : g_msb_or
    assign msb = grp_p[N-1] & ~grp_g[N-1];
  end else begin : g_msb_xor
    assign msb = grp_p[N-1];
  end

  assign r_o = {msb, low_sum};

  // checks against wide arithmetic
  logic [N:0]  wide_sum;
  logic [63:0] ref_val;
  assign wide_sum = {1'b0, c_i} + {1'b0, s_i};
  assign ref_val  = (64'(c_i) + 64'(s_i) + 64'd1) % ((64'd1 << N) + 64'd1);

  always_comb begin
    AST_RESIDUE: assert (65'(r_o) == {1'b0, ref_val})  // R1
      else $error("residue mismatch");
    AST_NO_OVERFLOW: assert (r_o <= {1'b1, {N{1'b0}}})  // R1
      else $error("result above modulus range");
    AST_CARRY_OUT: assert (grp_g[N-1] == wide_sum[N])  // R2
      else $error("tree carry-out mismatch");
    AST_MSB_IFF_COMPLEMENT: assert (r_o[N] == ((c_i ^ s_i) == {N{1'b1}}))  // R4
      else $error("msb detection mismatch");
    if (r_o[N]) begin
      AST_MSB_LOW_ZERO: assert (r_o[N-1:0] == '0)  // R5
        else $error("msb set with nonzero low bits");
    end
  end

endmodule

// File: tb/test_mod2n1_eac_adder.sv
`timescale 1ns/1ps
module test_mod2n1_eac_adder;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  int n_checks = 0;
  int n_errors = 0;
  int     cur_n;
  longint cur_c, cur_s;

  logic [1:0]  c2, s2;   logic [2:0]  r2x, r2o;
  logic [3:0]  c4, s4;   logic [4:0]  r4x, r4o;
  logic [5:0]  c6, s6;   logic [6:0]  r6x, r6o;
  logic [15:0] c16, s16; logic [16:0] r16x, r16o;
  logic [31:0] c32, s32; logic [32:0] r32x, r32o;

  mod2n1_eac_adder #(.N(6), .PROP(eac_pkg::PROP_XOR)) i_mod2n1_eac_adder (.c_i(c6), .s_i(s6), .r_o(r6x));
  mod2n1_eac_adder #(.N(6), .PROP(eac_pkg::PROP_OR))  i_n6_or  (.c_i(c6), .s_i(s6), .r_o(r6o));
  mod2n1_eac_adder #(.N(2), .PROP(eac_pkg::PROP_XOR)) i_n2_xor (.c_i(c2), .s_i(s2), .r_o(r2x));
  mod2n1_eac_adder #(.N(2), .PROP(eac_pkg::PROP_OR))  i_n2_or  (.c_i(c2), .s_i(s2), .r_o(r2o));
  mod2n1_eac_adder #(.N(4), .PROP(eac_pkg::PROP_XOR)) i_n4_xor (.c_i(c4), .s_i(s4), .r_o(r4x));
  mod2n1_eac_adder #(.N(4), .PROP(eac_pkg::PROP_OR))  i_n4_or  (.c_i(c4), .s_i(s4), .r_o(r4o));
  mod2n1_eac_adder #(.N(16), .PROP(eac_pkg::PROP_XOR)) i_n16_xor (.c_i(c16), .s_i(s16), .r_o(r16x));
  mod2n1_eac_adder #(.N(16), .PROP(eac_pkg::PROP_OR))  i_n16_or  (.c_i(c16), .s_i(s16), .r_o(r16o));
  mod2n1_eac_adder #(.N(32), .PROP(eac_pkg::PROP_XOR)) i_n32_xor (.c_i(c32), .s_i(s32), .r_o(r32x));
  mod2n1_eac_adder #(.N(32), .PROP(eac_pkg::PROP_OR))  i_n32_or  (.c_i(c32), .s_i(s32), .r_o(r32o));

  function automatic longint exp_res(int n, longint c, longint s);
    return (c + s + 64'sd1) % ((64'sd1 <<< n) + 64'sd1);
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s n=%0d c=%0h s=%0h: actual %0h expected %0h",
               tag, cur_n, cur_c, cur_s, act, exp);
    end
  endtask

  task automatic check_pair(int n, longint c, longint s, longint rx, longint ro);
    longint mask = (64'sd1 <<< n) - 64'sd1;
    longint top  = 64'sd1 <<< n;
    longint e    = exp_res(n, c, s);
    logic   comp = ((c ^ s) & mask) == mask;
    cur_n = n; cur_c = c; cur_s = s;
    chk("R1", rx, e);
    chk("R6", ro, rx);
    chk("R4", (rx >>> n) & 64'sd1, longint'(comp));
    if (comp)            chk("R5", rx, top);
    else if (c + s >= top) chk("R2", rx, c + s - top);
    else                 chk("R3", rx, c + s + 64'sd1);
    if (n == 2 || n == 32) chk("R7", rx, e);
  endtask

  task automatic drive16(logic [15:0] a, logic [15:0] b);
    @(posedge clk); c16 = a; s16 = b;
    @(negedge clk); check_pair(16, longint'(a), longint'(b), longint'(r16x), longint'(r16o));
  endtask

  task automatic drive32(logic [31:0] a, logic [31:0] b);
    @(posedge clk); c32 = a; s32 = b;
    @(negedge clk); check_pair(32, longint'(a), longint'(b), longint'(r32x), longint'(r32o));
  endtask

  initial begin
    void'($urandom(32'd1234));
    c2 = '0; s2 = '0; c4 = '0; s4 = '0; c6 = '0; s6 = '0;
    c16 = '0; s16 = '0; c32 = '0; s32 = '0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;

    // R8: all-zero inputs give 1
    @(negedge clk);
    cur_n = 6; cur_c = 0; cur_s = 0;
    chk("R8", longint'(r6x), 64'sd1);
    chk("R8", longint'(r16x), 64'sd1);
    // R8: all-ones inputs give 2^N-2
    @(posedge clk); c6 = '1; s6 = '1; c16 = '1; s16 = '1; c32 = '1; s32 = '1;
    @(negedge clk);
    cur_c = -1; cur_s = -1;
    chk("R8", longint'(r6x), 64'sd62);
    chk("R8", longint'(r16x), 64'sd65534);
    chk("R8", longint'(r32x), (64'sd1 <<< 32) - 64'sd2);

    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        @(posedge clk); c2 = 2'(a); s2 = 2'(b);
        @(negedge clk); check_pair(2, longint'(a), longint'(b), longint'(r2x), longint'(r2o));
      end
    end
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        @(posedge clk); c4 = 4'(a); s4 = 4'(b);
        @(negedge clk); check_pair(4, longint'(a), longint'(b), longint'(r4x), longint'(r4o));
      end
    end
    for (int a = 0; a < 64; a++) begin
      for (int b = 0; b < 64; b++) begin
        @(posedge clk); c6 = 6'(a); s6 = 6'(b);
        @(negedge clk); check_pair(6, longint'(a), longint'(b), longint'(r6x), longint'(r6o));
      end
    end

    // directed complementary and boundary pairs for wide widths
    drive16(16'h0000, 16'hffff);
    drive16(16'ha5a5, 16'h5a5a);
    drive16(16'h8000, 16'h8000);
    drive16(16'h7fff, 16'h8001);
    drive32(32'h0000_0000, 32'hffff_ffff);
    drive32(32'h8000_0000, 32'h8000_0000);
    drive32(32'h1234_5678, ~32'h1234_5678);
    drive32(32'h0000_0001, 32'hffff_ffff);

    for (int k = 0; k < 2000; k++) begin
      logic [15:0] a = 16'($urandom);
      logic [15:0] b = (k % 8 == 0) ? ~a : 16'($urandom);
      drive16(a, b);
    end
    for (int k = 0; k < 500; k++) begin
      logic [31:0] a = $urandom;
      logic [31:0] b = (k % 8 == 0) ? ~a : $urandom;
      drive32(a, b);
    end

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule